// File: doc/BRIEF.md
# Dual-Strobe DRAM Cycle Classifier

This block watches the active-low control pins of an asynchronous 16-bit DRAM that has one column strobe per byte. It samples those pins on a fast system clock and names each row-strobe cycle once it has ended. The possible names are read, read with the data output disabled, early write, delayed write, read-modify-write, refresh with a column strobe held before the row strobe, and refresh with the row strobe only. With each report the block also gives the byte lanes that took part and the state the data pins were in: driven, high-impedance or undefined.

The column phase of a cycle opens at the first byte strobe that falls and closes at the last one that rises. Each strobe adds its own lane to the lane mask. The block decides between early and delayed write by checking whether the write enable was already low when the column phase opened. A cycle that breaks the legal patterns is still reported, and it also raises an error flag. The block suits a bus monitor or a protocol checker that sits beside a memory controller.

Top module: `dcd_cycle_decoder`

## Requirements
- R1: While reset is asserted and after it is released, the outputs read cyc_type = 0 (standby), lane_mask = 00, out_state = 0 (high-impedance), cyc_done = 0 and cyc_err = 0.
- R2: Each row-strobe low period produces exactly one cyc_done pulse, one clock wide, a few clocks after the row strobe rises. cyc_type, lane_mask, out_state and cyc_err change only on that clock and hold their values at all other times.
- R3: Write enable high, and output enable pulled low during the column phase, gives cyc_type = 1 (read) and out_state = 1 (driven). lane_mask bit 0 stands for the lower byte strobe and bit 1 for the upper one.
- R4: Write enable high, with output enable high for the whole column phase, gives cyc_type = 7 (read, output disabled) and out_state = 0.
- R5: Write enable already low when the column phase opens gives cyc_type = 2 (early write) and out_state = 0, whatever output enable does.
- R6: Write enable falling inside the column phase, with no earlier low on output enable, gives cyc_type = 3 (delayed write) and out_state = 2 (undefined).
- R7: Output enable going low and then high, followed by a fall of write enable, gives cyc_type = 4 (read-modify-write) and out_state = 1.
- R8: Either byte strobe low when the row strobe falls gives cyc_type = 5 (refresh with column strobe first), lane_mask = 00 and out_state = 0. One strobe on its own is enough.
- R9: A row-strobe low period in which no byte strobe falls gives cyc_type = 6 (row-only refresh), lane_mask = 00 and out_state = 0.
- R10: The two byte strobes form a single column phase, from the earliest fall to the latest rise, even when their edges are staggered. lane_mask is the union of the lanes whose strobe went low.
- R11: cyc_err is set with the report when write enable falls while output enable is low, or when a second column phase opens in the same row cycle. Every legal cycle reports cyc_err = 0.
- R12: While the row strobe is high, activity on the byte strobes, write enable and output enable produces no report and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, at least four times faster than the shortest strobe pulse |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| lcas_n | input | 1 | Lower-byte column strobe, active low, asynchronous |
| ucas_n | input | 1 | Upper-byte column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| cyc_type | output | 3 | Code of the last completed cycle |
| lane_mask | output | 2 | Lanes of the last cycle (bit 0 lower, bit 1 upper) |
| out_state | output | 2 | Data pin state: 0 high-impedance, 1 driven, 2 undefined |
| cyc_done | output | 1 | One-clock pulse when a new report is loaded |
| cyc_err | output | 1 | The last cycle broke a legal pattern |

## Verification
The assertions assume that every pin level lasts at least two sampling clocks, so that no strobe pulse is lost in the synchronizer. They also assume that each row-strobe low period is separated by a clear high period. The bench holds each level for two or four clocks and drives its inputs on the falling clock edge. It offsets staggered byte strobes by two clocks, so that every edge reaches the classifier as a separate, ordered event.

// File: rtl/dcd_pkg.sv
// Package: shared codes and pin indices for the DRAM cycle classifier.
// Assumes: pins are packed into one vector in the index order below.
package dcd_pkg;

    // Cycle-type codes reported on cyc_type.
    typedef enum logic [2:0] {
        CY_STANDBY  = 3'd0,
        CY_READ     = 3'd1,
        CY_EARLY_WR = 3'd2,
        CY_DELAY_WR = 3'd3,
        CY_RMW      = 3'd4,
        CY_CBR      = 3'd5,
        CY_RAS_ONLY = 3'd6,
        CY_READ_HIZ = 3'd7
    } cyc_e;

    // Data pin state reported on out_state.
    typedef enum logic [1:0] {
        DQ_OPEN  = 2'd0,
        DQ_VALID = 2'd1,
        DQ_UNDEF = 2'd2
    } dq_e;

    // Bit positions of the pins in the sampled vector.
    localparam int PIN_RAS  = 0;
    localparam int PIN_LCAS = 1;
    localparam int PIN_UCAS = 2;
    localparam int PIN_WE   = 3;
    localparam int PIN_OE   = 4;
    localparam int N_PINS   = 5;
    // Pins whose previous sample is kept for edge detection (all but OE).
    localparam int N_EDGE   = 4;
    localparam int N_LANES  = 2;

endpackage

// File: rtl/dcd_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pins.
// Assumes: each pin is sampled on its own; levels last several clocks,
// so skew between the bits of the vector does not matter.
module dcd_sync #(
    parameter int               W       = 5,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] stage_q;

    // Shift the pins through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[LAST];

endmodule

// File: rtl/dcd_cycle_track.sv
// Module: follows one row-strobe cycle through its events and classifies it.
// Assumes: s_pins is the synchronized pin vector and p_pins the same
// vector one clock older. All pins are active low.
module dcd_cycle_track
    import dcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] s_pins,
    input  logic [N_EDGE-1:0] p_pins,
    output logic              ras_rise,
    output cyc_e              cls_type,
    output logic [N_LANES-1:0] cls_mask,
    output dq_e               cls_state,
    output logic              cls_err
);

    logic s_ras, s_lcas, s_ucas, s_we, s_oe;
    logic p_ras, p_lcas, p_ucas, p_we;
    logic ras_fall;
    logic col_now, col_prev, col_start, col_end;
    logic read_window, we_fall_ev;

    // Per-cycle event flags.
    logic              cbr_q;
    logic              cas_seen_q;
    logic              mode_done_q;
    logic              we_early_q;
    logic              we_fell_q;
    logic              oe_low_q;
    logic              err_q;
    logic [N_LANES-1:0] mask_q;

    assign s_ras  = s_pins[PIN_RAS];
    assign s_lcas = s_pins[PIN_LCAS];
    assign s_ucas = s_pins[PIN_UCAS];
    assign s_we   = s_pins[PIN_WE];
    assign s_oe   = s_pins[PIN_OE];
    assign p_ras  = p_pins[PIN_RAS];
    assign p_lcas = p_pins[PIN_LCAS];
    assign p_ucas = p_pins[PIN_UCAS];
    assign p_we   = p_pins[PIN_WE];

    // Edge and column-phase events derived from the current and previous samples.
    always_comb begin
        ras_fall    = p_ras && !s_ras;
        ras_rise    = !p_ras && s_ras;
        col_now     = !s_lcas || !s_ucas;
        col_prev    = !p_lcas || !p_ucas;
        col_start   = col_now && !col_prev;
        col_end     = !col_now && col_prev;
        read_window = cas_seen_q && !we_early_q && !we_fell_q;
        we_fall_ev  = p_we && !s_we && read_window;
    end

    // Record the events of the current row-strobe low period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cbr_q       <= 1'b0;
            cas_seen_q  <= 1'b0;
            mode_done_q <= 1'b0;
            we_early_q  <= 1'b0;
            we_fell_q   <= 1'b0;
            oe_low_q    <= 1'b0;
            err_q       <= 1'b0;
            mask_q      <= '0;
        end else if (ras_fall) begin
            cbr_q       <= !s_lcas || !s_ucas;
            cas_seen_q  <= 1'b0;
            mode_done_q <= 1'b0;
            we_early_q  <= 1'b0;
            we_fell_q   <= 1'b0;
            oe_low_q    <= 1'b0;
            err_q       <= 1'b0;
            mask_q      <= '0;
        end else if (!s_ras && !p_ras && !cbr_q) begin
            if (col_start) begin
                if (mode_done_q) begin
                    err_q <= 1'b1;
                end else begin
                    cas_seen_q <= 1'b1;
                    we_early_q <= !s_we;
                end
            end
            if (col_end) begin
                mode_done_q <= 1'b1;
            end
            if (col_now) begin
                mask_q <= mask_q | {!s_ucas, !s_lcas};
            end
            if (read_window && !s_oe) begin
                oe_low_q <= 1'b1;
            end
            if (we_fall_ev) begin
                we_fell_q <= 1'b1;
                if (!s_oe) err_q <= 1'b1;
            end
        end
    end

    // Map the recorded flags to a cycle type, lanes and data pin state.
    always_comb begin
        cls_err  = err_q;
        cls_mask = mask_q;
        if (cbr_q) begin
            cls_type  = CY_CBR;
            cls_mask  = '0;
            cls_state = DQ_OPEN;
        end else if (!cas_seen_q) begin
            cls_type  = CY_RAS_ONLY;
            cls_mask  = '0;
            cls_state = DQ_OPEN;
        end else if (we_early_q) begin
            cls_type  = CY_EARLY_WR;
            cls_state = DQ_OPEN;
        end else if (we_fell_q) begin
            cls_type  = oe_low_q ? CY_RMW : CY_DELAY_WR;
            cls_state = oe_low_q ? DQ_VALID : DQ_UNDEF;
        end else begin
            cls_type  = oe_low_q ? CY_READ : CY_READ_HIZ;
            cls_state = oe_low_q ? DQ_VALID : DQ_OPEN;
        end
    end

endmodule

// File: rtl/dcd_cycle_decoder.sv
// Module: top of the dual-strobe DRAM cycle classifier.
// Synchronizes the five control pins, keeps one older sample for edge
// detection, and loads one report for each completed row-strobe cycle.
// Assumes: clk is at least four times faster than the shortest pin level.
module dcd_cycle_decoder
    import dcd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ras_n,
    input  logic       lcas_n,
    input  logic       ucas_n,
    input  logic       we_n,
    input  logic       oe_n,
    output logic [2:0] cyc_type,
    output logic [1:0] lane_mask,
    output logic [1:0] out_state,
    output logic       cyc_done,
    output logic       cyc_err
);

    logic [N_PINS-1:0]  raw_pins;
    logic [N_PINS-1:0]  s_pins;
    logic [N_EDGE-1:0]  p_pins;
    logic               ras_rise;
    cyc_e               cls_type;
    logic [N_LANES-1:0] cls_mask;
    dq_e                cls_state;
    logic               cls_err;

    // Pack the pins in package index order.
    always_comb begin
        raw_pins           = '1;
        raw_pins[PIN_RAS]  = ras_n;
        raw_pins[PIN_LCAS] = lcas_n;
        raw_pins[PIN_UCAS] = ucas_n;
        raw_pins[PIN_WE]   = we_n;
        raw_pins[PIN_OE]   = oe_n;
    end

    dcd_sync #(
        .W       (N_PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({N_PINS{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_pins),
        .dout  (s_pins)
    );

    // Keep the previous sample of the edge-tracked pins.
    always_ff @(posedge clk) begin
        if (!rst_n) p_pins <= '1;
        else        p_pins <= s_pins[N_EDGE-1:0];
    end

    dcd_cycle_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_pins    (s_pins),
        .p_pins    (p_pins),
        .ras_rise  (ras_rise),
        .cls_type  (cls_type),
        .cls_mask  (cls_mask),
        .cls_state (cls_state),
        .cls_err   (cls_err)
    );

    // Load the report and pulse done when the row strobe rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_type  <= CY_STANDBY;
            lane_mask <= '0;
            out_state <= DQ_OPEN;
            cyc_err   <= 1'b0;
            cyc_done  <= 1'b0;
        end else begin
            cyc_done <= ras_rise;
            if (ras_rise) begin
                cyc_type  <= cls_type;
                lane_mask <= cls_mask;
                out_state <= cls_state;
                cyc_err   <= cls_err;
            end
        end
    end

endmodule

// File: rtl/dcd_checker.sv
// Module: property checker for the cycle classifier, attached by bind.
// Assumes: it sees only the top-level ports.
module dcd_checker
    import dcd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cyc_type,
    input logic [1:0] lane_mask,
    input logic [1:0] out_state,
    input logic       cyc_done,
    input logic       cyc_err
);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);

    assert_report_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_done |-> ($stable(cyc_type) && $stable(lane_mask)
                       && $stable(out_state) && $stable(cyc_err)));

    assert_no_standby_report_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> cyc_type != CY_STANDBY);

    assert_read_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && !cyc_err && (cyc_type == CY_READ || cyc_type == CY_RMW))
        |-> (lane_mask != 2'b00 && out_state == DQ_VALID));  // also R7

    assert_hiz_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && cyc_type == CY_READ_HIZ) |-> out_state == DQ_OPEN);

    assert_early_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && cyc_type == CY_EARLY_WR) |-> out_state == DQ_OPEN);

    assert_delay_undef_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && cyc_type == CY_DELAY_WR) |-> out_state == DQ_UNDEF);

    assert_refresh_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && (cyc_type == CY_CBR || cyc_type == CY_RAS_ONLY))
        |-> (lane_mask == 2'b00 && out_state == DQ_OPEN));  // also R9

    assert_state_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_state != 2'b11);

endmodule

bind dcd_cycle_decoder dcd_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_type  (cyc_type),
    .lane_mask (lane_mask),
    .out_state (out_state),
    .cyc_done  (cyc_done),
    .cyc_err   (cyc_err)
);

// File: tb/tb_dcd_cycle_decoder.sv
// Bench: sweeps every operation over every lane set, with and without
// staggered strobes, and compares each report with values derived from
// the requirements.
module tb_dcd_cycle_decoder;

    localparam time CLK_PERIOD = 10;
    localparam int  PH         = 4;

    localparam int OP_READ  = 0;
    localparam int OP_HIZ   = 1;
    localparam int OP_EARLY = 2;
    localparam int OP_DELAY = 3;
    localparam int OP_RMW   = 4;
    localparam int OP_CBR   = 5;
    localparam int OP_RONLY = 6;
    localparam int OP_ERR_WEOE = 7;
    localparam int OP_ERR_TWO  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [2:0] cyc_type;
    logic [1:0] lane_mask;
    logic [1:0] out_state;
    logic       cyc_done;
    logic       cyc_err;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 1'b0;

    dcd_cycle_decoder dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_n     (ras_n),
        .lcas_n    (lcas_n),
        .ucas_n    (ucas_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .cyc_type  (cyc_type),
        .lane_mask (lane_mask),
        .out_state (out_state),
        .cyc_done  (cyc_done),
        .cyc_err   (cyc_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive the selected strobes low or high, optionally staggered.
    task automatic strobes(input logic [1:0] lanes, input bit stagger, input logic lvl);
        if (stagger && lanes == 2'b11) begin
            lcas_n = lvl;
            idle(2);
            ucas_n = lvl;
        end else begin
            if (lanes[0]) lcas_n = lvl;
            if (lanes[1]) ucas_n = lvl;
        end
    endtask

    function automatic string req_of(input int op);
        case (op)
            OP_READ:  return "R3";
            OP_HIZ:   return "R4";
            OP_EARLY: return "R5";
            OP_DELAY: return "R6";
            OP_RMW:   return "R7";
            OP_CBR:   return "R8";
            OP_RONLY: return "R9";
            default:  return "R11";
        endcase
    endfunction

    // Run one row cycle of the given kind and check its report.
    task automatic run_op(input int op, input logic [1:0] lanes, input bit stagger);
        int seen;
        int got_type, got_mask, got_state, got_err;
        int exp_type, exp_mask, exp_state;
        seen = 0; got_type = 0; got_mask = 0; got_state = 0; got_err = 0;
        we_n = (op == OP_EARLY) ? 1'b0 : 1'b1;
        oe_n = 1'b1;
        idle(PH);
        if (op == OP_CBR) begin
            strobes(lanes, 1'b0, 1'b0);
            idle(PH);
            ras_n = 1'b0;
            oe_n  = 1'b0;
            idle(2*PH);
            ras_n = 1'b1;
        end else begin
            ras_n = 1'b0;
            idle(PH);
            if (op != OP_RONLY) begin
                strobes(lanes, stagger, 1'b0);
                idle(PH);
                case (op)
                    OP_READ:  begin oe_n = 1'b0; idle(PH); oe_n = 1'b1; end
                    OP_EARLY: begin oe_n = 1'b0; idle(PH); oe_n = 1'b1; end
                    OP_DELAY: begin we_n = 1'b0; idle(PH); end
                    OP_RMW:   begin oe_n = 1'b0; idle(PH); oe_n = 1'b1; idle(PH);
                                    we_n = 1'b0; idle(PH); end
                    OP_ERR_WEOE: begin oe_n = 1'b0; idle(PH); we_n = 1'b0; idle(PH); end
                    OP_ERR_TWO:  begin strobes(lanes, 1'b0, 1'b1); idle(PH);
                                       strobes(lanes, 1'b0, 1'b0); idle(PH); end
                    default: idle(PH);
                endcase
                strobes(lanes, stagger, 1'b1);
            end
            idle(PH);
            we_n = 1'b1;
            oe_n = 1'b1;
            idle(PH);
            ras_n = 1'b1;
        end
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (cyc_done) begin
                seen++;
                got_type = cyc_type; got_mask = lane_mask;
                got_state = out_state; got_err = cyc_err;
            end
        end
        lcas_n = 1'b1;
        ucas_n = 1'b1;
        chk("R2", "done pulses", seen, 1);
        if (op == OP_ERR_WEOE || op == OP_ERR_TWO) begin
            chk("R11", "error flag", got_err, 1);
            return;
        end
        case (op)
            OP_READ:  begin exp_type = 1; exp_state = 1; end
            OP_HIZ:   begin exp_type = 7; exp_state = 0; end
            OP_EARLY: begin exp_type = 2; exp_state = 0; end
            OP_DELAY: begin exp_type = 3; exp_state = 2; end
            OP_RMW:   begin exp_type = 4; exp_state = 1; end
            OP_CBR:   begin exp_type = 5; exp_state = 0; end
            default:  begin exp_type = 6; exp_state = 0; end
        endcase
        exp_mask = (op == OP_CBR || op == OP_RONLY) ? 0 : int'(lanes);
        chk(req_of(op), "type", got_type, exp_type);
        chk(req_of(op), "state", got_state, exp_state);
        chk((op == OP_CBR || op == OP_RONLY) ? req_of(op) : "R10", "lanes", got_mask, exp_mask);
        chk("R11", "no error on legal cycle", got_err, 0);
    endtask

    // Toggle the other pins with the row strobe high; nothing may change.
    task automatic standby_probe();
        int t0, m0, s0, e0, pulses;
        t0 = cyc_type; m0 = lane_mask; s0 = out_state; e0 = cyc_err; pulses = 0;
        for (int k = 0; k < 16; k++) begin
            lcas_n = k[0]; ucas_n = k[1]; we_n = k[2]; oe_n = k[3];
            idle(2);
            if (cyc_done) pulses++;
        end
        lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (cyc_done) pulses++;
        end
        chk("R12", "standby pulses", pulses, 0);
        chk("R12", "standby type", cyc_type, t0);
        chk("R12", "standby lanes", lane_mask, m0);
        chk("R12", "standby state", out_state, s0);
        chk("R12", "standby error", cyc_err, e0);
    endtask

    initial begin
        idle(3);
        chk("R1", "reset type", cyc_type, 0);
        chk("R1", "reset lanes", lane_mask, 0);
        chk("R1", "reset state", out_state, 0);
        chk("R1", "reset done", cyc_done, 0);
        chk("R1", "reset error", cyc_err, 0);
        rst_n = 1'b1;
        idle(4);
        chk("R1", "after release type", cyc_type, 0);
        chk("R1", "after release done", cyc_done, 0);
        for (int op = 0; op <= OP_ERR_TWO; op++) begin
            for (int ln = 1; ln <= 3; ln++) begin
                for (int st = 0; st <= 1; st++) begin
                    run_op(op, 2'(ln), st[0]);
                end
            end
        end
        standby_probe();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog run did not complete");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

endmodule